// File: doc/BRIEF.md
# Operand address evaluator

This block resolves one operand specifier for a 16-bit machine with eight general registers. Any addressing mode may be used with any register. A specifier has a 3-bit mode and a 3-bit register number, and a separate flag marks the operand as a byte or a word. On `start` the block takes a snapshot of the whole register file. It then performs the memory reads the mode requires, one at a time, over a request/ready interface. When it finishes it returns the operand value, the effective address, a register-operand flag and the updated register file.

Register 7 is the program counter and register 6 is the stack pointer. Both are ordinary registers to the evaluator, so immediate and absolute operands need no decode of their own:

- Autoincrement on register 7 reads the word after the instruction, which gives an immediate operand.
- Autoincrement-deferred on register 7 uses that word as an address, which gives an absolute operand.
- Index modes on register 7 give addresses relative to the program counter.

Instruction fetch, the ALU and result write-back are outside this block.

Top module: `opnd_eval`

## Requirements
- R1: After reset, `done`, `mem_req`, `is_reg`, `opnd_val`, `eff_addr` and `regs_out` are all zero.
- R2: Mode 0 (register) reads no memory. One cycle after `start`, `done` pulses with `is_reg`=1 and `eff_addr`=0. `opnd_val` is the register for a word operand, or its low byte zero-extended for a byte operand.
- R3: Mode 1 (register deferred) reads the operand at the address held in the register and leaves all registers unchanged.
- R4: Mode 2 (autoincrement) reads the operand at the register's value, then adds the step to that register. The step is 1 for a byte operand on registers 0 to 5, and 2 in every other case (any word operand, and any operand on register 6 or 7).
- R5: Mode 3 (autoincrement deferred) reads a pointer word at the register's value, adds 2 to the register, and reads the operand at that pointer.
- R6: Mode 4 (autodecrement) subtracts the step (defined as in R4) from the register first, then reads the operand at the new value.
- R7: Mode 5 (autodecrement deferred) subtracts 2 from the register, reads a pointer word at the new value, and reads the operand at that pointer.
- R8: Mode 6 (index) reads an offset word at the program counter and adds 2 to the program counter. The effective address is the offset plus the base register. When the base is register 7, the program counter value after the advance is used.
- R9: Mode 7 (index deferred) forms the same address as R8, reads a pointer word there, and reads the operand at that pointer.
- R10: With register 7, mode 2 returns the word that follows as the operand and mode 3 uses that word as the effective address. In both cases the program counter advances by 2.
- R11: A byte operand read from memory is the low half of the word at an even address and the high half at an odd address, zero-extended in both cases.
- R12: `mem_req` and `mem_addr` stay unchanged while `mem_ready` is low, for a stall of any length. A read completes on the clock edge where `mem_req` and `mem_ready` are both high.
- R13: `done` is high for exactly one cycle. `opnd_val`, `eff_addr`, `is_reg` and `regs_out` change only in the cycle `done` rises, and hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin evaluation; ignored while busy |
| spec_mode | input | 3 | Addressing mode of the specifier |
| spec_reg | input | 3 | Register number of the specifier |
| byte_op | input | 1 | 1 for a byte operand, 0 for a word operand |
| regs_in | input | 128 | Register file snapshot, register i at bits [16i+15:16i] |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Byte address of the read |
| mem_ready | input | 1 | Read data valid; completes the request |
| mem_rdata | input | 16 | Word read at the address, with bit 0 of the address ignored |
| done | output | 1 | One-cycle completion pulse |
| opnd_val | output | 16 | Operand value |
| eff_addr | output | 16 | Effective address (0 for a register operand) |
| is_reg | output | 1 | Operand is a register |
| regs_out | output | 128 | Register file after side effects, same packing as regs_in |

## Verification
The hardest case to reach from the ports is a long memory stall landing in the middle of a chain of reads, such as the offset, pointer and operand reads of index-deferred mode. In that case the register side effects must stay pending across the wait. The bench memory model adds a random delay of 0 to 3 cycles to every read. Directed operations force a 12-cycle stall on each read of a deferred chain. Directed cases also cover the step rules: byte autoincrement and autodecrement on an ordinary register, the stack pointer and the program counter, plus the immediate, absolute and PC-relative uses of register 7. Random operations then chain the register file from one operation to the next, so the program counter keeps moving through memory.

// File: rtl/opnd_eval_pkg.sv
package opnd_eval_pkg;
  typedef enum logic [2:0] {
    M_REG    = 3'd0,
    M_DEF    = 3'd1,
    M_INC    = 3'd2,
    M_INCDEF = 3'd3,
    M_DEC    = 3'd4,
    M_DECDEF = 3'd5,
    M_IDX    = 3'd6,
    M_IDXDEF = 3'd7
  } amode_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_INDEX,
    PH_PTR,
    PH_OPND
  } phase_t;
endpackage

// File: rtl/oe_step.sv
module oe_step #(
  parameter int W = 16,
  parameter int NREG = 8,
  localparam int RW = $clog2(NREG)
) (
  input  logic [2:0]    mode,
  input  logic [RW-1:0] rn,
  input  logic          byte_op,
  output logic [W-1:0]  step
);
  logic single;
  // Byte stride only for plain inc/dec on non SP/PC registers
  always_comb begin
    single = byte_op && (mode == 3'd2 || mode == 3'd4) && (rn < RW'(NREG - 2));
    step = single ? W'(1) : W'(2);
  end
endmodule

// File: rtl/oe_lane.sv
module oe_lane #(
  parameter int W = 16,
  localparam int H = W / 2
) (
  input  logic [W-1:0] word,
  input  logic         odd,
  input  logic         byte_op,
  output logic [W-1:0] val
);
  always_comb begin
    if (byte_op)
      val = {{(W - H){1'b0}}, (odd ? word[W-1:H] : word[H-1:0])};
    else
      val = word;
  end
endmodule

// File: rtl/opnd_eval.sv
module opnd_eval
  import opnd_eval_pkg::*;
#(
  parameter int W = 16,
  parameter int NREG = 8,
  localparam int RW = $clog2(NREG),
  localparam int PC = NREG - 1,
  localparam int H = W / 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [2:0]      spec_mode,
  input  logic [RW-1:0]   spec_reg,
  input  logic            byte_op,
  input  logic [NREG*W-1:0] regs_in,
  output logic            mem_req,
  output logic [W-1:0]    mem_addr,
  input  logic            mem_ready,
  input  logic [W-1:0]    mem_rdata,
  output logic            done,
  output logic [W-1:0]    opnd_val,
  output logic [W-1:0]    eff_addr,
  output logic            is_reg,
  output logic [NREG*W-1:0] regs_out
);
  localparam logic [W-1:0] TWO = W'(2);

  logic [W-1:0] wk [NREG];
  phase_t       ph;
  amode_t       md;
  logic [RW-1:0] rn;
  logic         bop;

  logic [W-1:0] rv_in, pc_in, step, lane_val, reg_val, idx_ea;
  amode_t       smode;

  assign rv_in  = regs_in[int'(spec_reg)*W +: W];
  assign pc_in  = regs_in[PC*W +: W];
  assign smode  = amode_t'(spec_mode);
  assign idx_ea = mem_rdata + wk[rn];

  oe_step #(.W(W), .NREG(NREG)) u_step (
    .mode(spec_mode), .rn(spec_reg), .byte_op(byte_op), .step(step)
  );

  oe_lane #(.W(W)) u_mem_lane (
    .word(mem_rdata), .odd(mem_addr[0]), .byte_op(bop), .val(lane_val)
  );

  oe_lane #(.W(W)) u_reg_lane (
    .word(rv_in), .odd(1'b0), .byte_op(byte_op), .val(reg_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      md       <= M_REG;
      rn       <= '0;
      bop      <= 1'b0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      done     <= 1'b0;
      opnd_val <= '0;
      eff_addr <= '0;
      is_reg   <= 1'b0;
      regs_out <= '0;
      for (int i = 0; i < NREG; i++) wk[i] <= '0;
    end else begin
      done <= 1'b0;
      case (ph)
        PH_IDLE: if (start) begin
          md  <= smode;
          rn  <= spec_reg;
          bop <= byte_op;
          for (int i = 0; i < NREG; i++) wk[i] <= regs_in[i*W +: W];
          case (smode)
            M_REG: begin
              opnd_val <= reg_val;
              eff_addr <= '0;
              is_reg   <= 1'b1;
              done     <= 1'b1;
              regs_out <= regs_in;
            end
            M_DEF: begin
              mem_req <= 1'b1; mem_addr <= rv_in; ph <= PH_OPND;
            end
            M_INC: begin
              wk[spec_reg] <= rv_in + step;
              mem_req <= 1'b1; mem_addr <= rv_in; ph <= PH_OPND;
            end
            M_INCDEF: begin
              wk[spec_reg] <= rv_in + step;
              mem_req <= 1'b1; mem_addr <= rv_in; ph <= PH_PTR;
            end
            M_DEC: begin
              wk[spec_reg] <= rv_in - step;
              mem_req <= 1'b1; mem_addr <= rv_in - step; ph <= PH_OPND;
            end
            M_DECDEF: begin
              wk[spec_reg] <= rv_in - step;
              mem_req <= 1'b1; mem_addr <= rv_in - step; ph <= PH_PTR;
            end
            default: begin
              wk[PC] <= pc_in + TWO;
              mem_req <= 1'b1; mem_addr <= pc_in; ph <= PH_INDEX;
            end
          endcase
        end
        PH_INDEX: if (mem_ready) begin
          mem_addr <= idx_ea;
          ph       <= (md == M_IDX) ? PH_OPND : PH_PTR;
        end
        PH_PTR: if (mem_ready) begin
          mem_addr <= mem_rdata;
          ph       <= PH_OPND;
        end
        PH_OPND: if (mem_ready) begin
          opnd_val <= lane_val;
          eff_addr <= mem_addr;
          is_reg   <= 1'b0;
          done     <= 1'b1;
          mem_req  <= 1'b0;
          ph       <= PH_IDLE;
          for (int i = 0; i < NREG; i++) regs_out[i*W +: W] <= wk[i];
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr));

  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R13
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(opnd_val) || !$stable(regs_out) || !$stable(eff_addr)) |-> done);

  // R2
  reg_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_IDLE && start && spec_mode == 3'd0) |=> done && is_reg && eff_addr == '0 && !mem_req);

  // R11
  byte_zext_chk: assert property (@(posedge clk) disable iff (rst)
    done && bop |-> opnd_val[W-1:H] == '0);
endmodule

// File: tb/sim_opnd_eval.sv
`timescale 1ns/1ps
module sim_opnd_eval;
  localparam int W = 16;
  localparam int N = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, start, byte_op, mem_req, mem_ready, done, is_reg;
  logic [2:0] spec_mode, spec_reg;
  logic [N*W-1:0] regs_in, regs_out;
  logic [W-1:0] mem_addr, mem_rdata, opnd_val, eff_addr;

  opnd_eval u0 (
    .clk(clk), .rst(rst), .start(start), .spec_mode(spec_mode), .spec_reg(spec_reg),
    .byte_op(byte_op), .regs_in(regs_in), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .done(done), .opnd_val(opnd_val),
    .eff_addr(eff_addr), .is_reg(is_reg), .regs_out(regs_out)
  );

  logic [W-1:0] mem [256];
  logic [W-1:0] cur [N];
  int total = 0, bad = 0, cyc = 0, dly = 0;
  bit long_stall = 0;

  always @(posedge clk) cyc++;

  initial begin
    wait (cyc > 150000);
    bad++;
    $display("FAIL watchdog act=%0d exp<150000", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(negedge clk) begin
    if (mem_ready) mem_ready <= 1'b0;
    else if (mem_req) begin
      if (dly == 0) begin
        mem_ready <= 1'b1;
        mem_rdata <= mem[mem_addr[8:1]];
        dly <= long_stall ? 12 : int'($urandom % 4);
      end else dly <= dly - 1;
    end
  end

  function automatic logic [W-1:0] rdw(logic [W-1:0] a);
    return mem[a[8:1]];
  endfunction

  function automatic string tag_of(int m, int rn);
    if (rn == 7 && (m == 2 || m == 3)) return "R10";
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string tg, string what, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tg, what, act, exp);
    end
  endtask

  task automatic run_op(int m, int rn, bit b, string tgo = "");
    logic [W-1:0] r [N];
    logic [W-1:0] ea, val, st, hv;
    logic isr;
    string tg;
    int guard;
    tg = (tgo != "") ? tgo : tag_of(m, rn);
    for (int i = 0; i < N; i++) begin r[i] = cur[i]; regs_in[i*W +: W] = cur[i]; end
    st = (b && rn < 6) ? 16'd1 : 16'd2;
    isr = 0; ea = 0;
    case (m)
      0: isr = 1;
      1: ea = r[rn];
      2: begin ea = r[rn]; r[rn] = r[rn] + st; end
      3: begin ea = rdw(r[rn]); r[rn] = r[rn] + 2; end
      4: begin r[rn] = r[rn] - st; ea = r[rn]; end
      5: begin r[rn] = r[rn] - 2; ea = rdw(r[rn]); end
      default: begin
        hv = rdw(r[7]); r[7] = r[7] + 2; ea = hv + r[rn];
        if (m == 7) ea = rdw(ea);
      end
    endcase
    if (isr) val = b ? {8'h00, r[rn][7:0]} : r[rn];
    else begin
      hv = rdw(ea);
      val = b ? {8'h00, (ea[0] ? hv[15:8] : hv[7:0])} : hv;
    end
    @(negedge clk);
    start = 1; spec_mode = 3'(m); spec_reg = 3'(rn); byte_op = b;
    @(negedge clk);
    start = 0;
    guard = 0;
    while (!done && guard < 500) begin @(negedge clk); guard++; end
    chk(tg, "done", {15'd0, done}, 16'd1);
    chk(tg, "value", opnd_val, val);
    chk(tg, "ea", eff_addr, ea);
    chk(tg, "is_reg", {15'd0, is_reg}, {15'd0, isr});
    for (int i = 0; i < N; i++) chk(tg, "reg", regs_out[i*W +: W], r[i]);
    if (b) chk("R11", "byte hi", {8'h00, opnd_val[15:8]}, 16'h0000);
    @(negedge clk);
    @(negedge clk);
    chk("R13", "done low", {15'd0, done}, 16'd0);
    chk("R13", "hold value", opnd_val, val);
    chk("R13", "hold ea", eff_addr, ea);
    for (int i = 0; i < N; i++) cur[i] = r[i];
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 256; i++) mem[i] = 16'((i * 40503) ^ 16'h5a3c);
    rst = 1; start = 0; spec_mode = 0; spec_reg = 0; byte_op = 0;
    regs_in = '0; mem_ready = 0; mem_rdata = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1", "done", {15'd0, done}, 16'd0);
    chk("R1", "mem_req", {15'd0, mem_req}, 16'd0);
    chk("R1", "is_reg", {15'd0, is_reg}, 16'd0);
    chk("R1", "value", opnd_val, 16'd0);
    chk("R1", "ea", eff_addr, 16'd0);
    chk("R1", "regs", regs_out[15:0] | regs_out[127:112], 16'd0);

    for (int i = 0; i < N; i++) cur[i] = 16'(16'h0100 + i * 16'h0022);
    cur[6] = 16'h01F0; cur[7] = 16'h0040;
    run_op(0, 3, 1);
    run_op(0, 5, 0);
    run_op(1, 2, 0);
    run_op(2, 0, 1);
    run_op(2, 0, 1);
    run_op(2, 6, 1);
    run_op(2, 7, 1);
    run_op(2, 7, 0);
    run_op(3, 7, 0);
    run_op(3, 1, 1);
    run_op(4, 3, 1);
    run_op(4, 6, 1);
    run_op(4, 2, 0);
    run_op(5, 4, 0);
    run_op(6, 7, 0);
    run_op(6, 5, 1);
    run_op(7, 1, 0);
    run_op(7, 7, 1);
    long_stall = 1;
    run_op(7, 2, 0, "R12");
    run_op(5, 6, 1, "R12");
    long_stall = 0;
    for (int k = 0; k < 300; k++) begin
      if (k % 40 == 0)
        for (int i = 0; i < N; i++) cur[i] = 16'($urandom);
      run_op(int'($urandom % 8), int'($urandom % 8), 1'($urandom % 2));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule